// File: doc/BRIEF.md
# Four-Channel Interval Timer with Reset Trigger

This block provides four independent down-counting timers behind a small register port, plus a register that produces a system-reset request. Software programs a reload length for each channel and then writes one shared control word. Each channel's 4-bit field in that word starts the channel when the field is nonzero and the channel's length is nonzero. Any other field value stops the channel. A running channel decrements once per prescaler tick. On the tick that finds it at zero it reloads its length and emits a one-cycle interrupt pulse on its own line. The live count of every channel can be read back at any time.

A write of the single value 0x10000 to the reset register raises a one-cycle reset request. Every other value written there has no effect. The prescaler tick arrives as a clock-enable input, so the timer rate is set by whatever drives that input. The asynchronous active-low reset is released synchronously inside the block.

Top module: `quad_interval_timer`

## Requirements
- R1: After reset every interrupt line and the reset request are low, every count reads 0 and every length is 0. As a result, a control write that enables a channel whose length was never written leaves that channel stopped at 0.
- R2: A write to the control register (byte offset 0x10) starts channel i when control bits [4i+3:4i] are nonzero and that channel's length is nonzero. In the cycle after the write the channel's count equals its length.
- R3: A running channel's count falls by exactly one on each clock cycle in which tick_en is high and the count is nonzero. With tick_en low the count does not change.
- R4: On a tick that finds a running channel at 0, the channel reloads its length and its irq bit goes high for exactly one cycle, starting in the cycle after that tick. The period is therefore length+1 ticks.
- R5: A control write whose field for channel i is zero, or that targets a channel whose length is 0, stops that channel. A stopped channel holds its count and raises no interrupt.
- R6: The channels are independent. A control write starts or stops each channel only according to its own field, and each length register (byte offsets 0x00, 0x04, 0x08, 0x0C for channels 0 to 3) affects only its own channel.
- R7: A write of exactly 0x10000 to byte offset 0x34 drives reset_req high for the single following cycle. Any other value at that offset, and the magic value at any other offset, leaves reset_req low.
- R8: Reading byte offsets 0x14, 0x18, 0x1C and 0x20 returns the live counts of channels 0 to 3. Every other offset reads 0.
- R9: Writing a length while a channel runs does not alter its current count. The new length takes effect at the next reload or start.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Prescaler tick; one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 4 | Per-channel one-cycle expiry pulse |
| reset_req | output | 1 | One-cycle system-reset request |

## Verification
Writes and ticks take effect at the clock edge that samples them. A count read through rdata shows the new value once that edge has passed, because rdata decodes addr combinationally. irq and reset_req are registered, so each pulse is high during the cycle after the tick or write that caused it and low again one cycle later. The bench applies inputs before an edge and updates its own model of the channels at that edge. It compares irq, reset_req and rdata for the current addr one time unit after the edge, so every result is checked in the cycle it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned LEN_BASE  = 32'h00;
  localparam int unsigned CTL_OFS   = 32'h10;
  localparam int unsigned VAL_BASE  = 32'h14;
  localparam int unsigned RST_OFS   = 32'h34;
  localparam int unsigned REG_STEP  = 4;
  localparam int unsigned FLD_W     = 4;
  localparam logic [31:0] RST_MAGIC = 32'h0001_0000;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_TMR-1:0]  len_we,
  output logic [N_TMR-1:0]  val_sel,
  output logic              ctl_we,
  output logic              rst_we
);
  for (genvar i = 0; i < N_TMR; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] LEN_A = ADDR_W'(LEN_BASE + REG_STEP * i);
    localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(VAL_BASE + REG_STEP * i);
    assign len_we[i]  = wr_en && (addr == LEN_A);
    assign val_sel[i] = (addr == VAL_A);
  end

  assign ctl_we = wr_en && (addr == ADDR_W'(CTL_OFS));
  assign rst_we = wr_en && (addr == ADDR_W'(RST_OFS));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             len_we,
  input  logic             ctl_we,
  input  logic [FLD_W-1:0] en_field,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] len_q, len_d, cnt_q, cnt_d;
  logic             run_q, run_d, irq_q, irq_d;
  logic             start_ok, len_en, cnt_en;

  assign start_ok = (|en_field) && (len_q != '0);

  always_comb begin
    len_d  = wdata;
    len_en = len_we;
    run_d  = run_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    cnt_en = 1'b0;
    if (ctl_we) begin
      run_d = start_ok;
      if (start_ok) begin
        cnt_d  = len_q;
        cnt_en = 1'b1;
      end
    end else if (run_q && tick_en) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) begin
        cnt_d = len_q;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (len_en) len_q <= len_d;
      if (cnt_en) cnt_q <= cnt_d;
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;

  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r4_irq_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tick_en && run_q));
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ctl_we) |=> $stable(cnt_q));
  a_r5_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctl_we) |=> ($stable(cnt_q) && !irq_q));
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (|en_field) && (len_q != '0)) |=> (run_q && (cnt_q == $past(len_q))));
  a_r9_len_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && !tick_en && !ctl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_rst_trig.sv
module tmr_rst_trig
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              reset_req
);
  logic req_q, req_d;

  always_comb req_d = rst_we && (wdata == DATA_W'(RST_MAGIC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign reset_req = req_q;

  a_r7_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(rst_we));
  a_r7_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_we |=> !reset_req);
endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [N_TMR-1:0]       irq,
  output logic                   reset_req
);
  localparam int CTL_BITS = N_TMR * FLD_W;

  logic              rst_m, rst_s;
  logic [N_TMR-1:0]  len_we, val_sel;
  logic              ctl_we, rst_we;
  logic [DATA_W-1:0] cnt [N_TMR];
  logic [DATA_W-1:0] rd_or [N_TMR+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  tmr_regdec #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
    .wr_en  (wr_en),
    .addr   (addr),
    .len_we (len_we),
    .val_sel(val_sel),
    .ctl_we (ctl_we),
    .rst_we (rst_we)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    tmr_channel #(.CNT_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_s),
      .tick_en (tick_en),
      .len_we  (len_we[i]),
      .ctl_we  (ctl_we),
      .en_field(wdata[FLD_W*i +: FLD_W]),
      .wdata   (wdata),
      .count   (cnt[i]),
      .irq     (irq[i])
    );
  end

  assign rd_or[0] = '0;
  for (genvar i = 0; i < N_TMR; i++) begin : g_rd
    assign rd_or[i+1] = rd_or[i] | (val_sel[i] ? cnt[i] : '0);
  end
  assign rdata = rd_or[N_TMR];

  tmr_rst_trig #(.DATA_W(DATA_W)) u_rst (
    .clk      (clk),
    .rst_n    (rst_s),
    .rst_we   (rst_we),
    .wdata    (wdata),
    .reset_req(reset_req)
  );

  initial begin
    a_r6_ctl_fits: assert (CTL_BITS <= DATA_W);
  end
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(val_sel));
endmodule

// File: tb/sim_quad_interval_timer.sv
module sim_quad_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        reset_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] m_len [4];
  logic [31:0] m_cnt [4];
  logic        m_run [4];
  logic [3:0]  m_irq;
  logic        m_req;

  always #2 clk = ~clk;

  quad_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .reset_req(reset_req)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a >= 8'h14 && a <= 8'h20 && a[1:0] == 2'b00) return m_cnt[(a - 8'h14) >> 2];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit tk, input bit wr, input logic [7:0] a, input logic [31:0] d);
    for (int i = 0; i < 4; i++) begin
      m_irq[i] = 1'b0;
      if (wr && a == 8'h10) begin
        if (d[4*i +: 4] != 4'h0 && m_len[i] != 0) begin
          m_run[i] = 1'b1;
          m_cnt[i] = m_len[i];
        end else begin
          m_run[i] = 1'b0;
        end
      end else if (m_run[i] && tk) begin
        if (m_cnt[i] == 0) begin
          m_cnt[i] = m_len[i];
          m_irq[i] = 1'b1;
        end else begin
          m_cnt[i] = m_cnt[i] - 1;
        end
      end
      if (wr && a == 8'(4 * i)) m_len[i] = d;
    end
    m_req = wr && a == 8'h34 && d == 32'h0001_0000;
  endtask

  task automatic cyc(input bit tk, input bit wr, input logic [7:0] a,
                     input logic [31:0] d, input string tag);
    tick_en = tk; wr_en = wr; addr = a; wdata = d;
    @(posedge clk);
    model_step(tk, wr, a, d);
    #1;
    check({tag, " irq"}, {28'h0, irq}, {28'h0, m_irq});
    check({tag, " reset_req"}, {31'h0, reset_req}, {31'h0, m_req});
    check({tag, " rdata"}, rdata, model_read(a));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = 8'h0; wdata = 32'h0;
    for (int i = 0; i < 4; i++) begin
      m_len[i] = 0; m_cnt[i] = 0; m_run[i] = 0;
    end
    m_irq = 4'h0; m_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state; enabling channels with zero length starts nothing
    for (int i = 0; i < 4; i++) cyc(1, 0, 8'(8'h14 + 4 * i), 0, "R1");
    cyc(1, 1, 8'h10, 32'hFFFF, "R1");
    for (int i = 0; i < 4; i++) cyc(1, 0, 8'(8'h14 + 4 * i), 0, "R1");

    // R2/R4: channel 0 length 3, start, run through two periods
    cyc(0, 1, 8'h00, 32'd3, "R6");
    cyc(0, 1, 8'h10, 32'h0000_0001, "R2");
    for (int k = 0; k < 9; k++) cyc(1, 0, 8'h14, 0, "R4");
    // R3: no ticks, count holds
    for (int k = 0; k < 4; k++) cyc(0, 0, 8'h14, 0, "R3");

    // R6: field for channel 2 only (bits [11:8]); channel 0 stops (R5)
    cyc(0, 1, 8'h08, 32'd2, "R6");
    cyc(0, 1, 8'h10, 32'h0000_0300, "R6");
    for (int k = 0; k < 7; k++) cyc(1, 0, 8'h1C, 0, "R5");
    cyc(1, 0, 8'h14, 0, "R5");

    // R9: length write while running leaves count alone
    cyc(0, 1, 8'h08, 32'd5, "R9");
    for (int k = 0; k < 10; k++) cyc(1, 0, 8'h1C, 0, "R9");

    // R7: reset trigger near misses and exact value
    cyc(0, 1, 8'h34, 32'h0001_0001, "R7");
    cyc(0, 1, 8'h34, 32'h0000_FFFF, "R7");
    cyc(0, 1, 8'h30, 32'h0001_0000, "R7");
    cyc(0, 1, 8'h34, 32'h0001_0000, "R7");
    cyc(0, 0, 8'h24, 0, "R7");

    // R8: unmapped and length offsets read 0
    cyc(0, 0, 8'h24, 0, "R8");
    cyc(0, 0, 8'h08, 0, "R8");
    cyc(0, 0, 8'h16, 0, "R8");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bit          tk = ($urandom % 3) == 0;
      int unsigned sel = $urandom % 16;
      logic [7:0]  a = 8'(8'h14 + 4 * ($urandom % 4));
      logic [31:0] d = 32'h0;
      bit          wr = 1'b0;
      if (sel == 0) begin
        wr = 1; a = 8'(4 * ($urandom % 4)); d = (($urandom % 8) == 0) ? 0 : 1 + $urandom % 9;
      end else if (sel == 1) begin
        wr = 1; a = 8'h10;
        for (int i = 0; i < 4; i++) d[4*i +: 4] = (($urandom % 3) == 0) ? 4'h0 : 4'($urandom);
      end else if (sel == 2) begin
        wr = 1; a = 8'h34; d = (($urandom % 2) == 0) ? 32'h0001_0000 : $urandom;
      end
      cyc(tk, wr, a, d, "R4");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule